// File: doc/BRIEF.md
# Serial Memory-Access Command Decoder

This block sits behind a UART receiver and transmitter and lets an external host peek and poke a 16-bit address space over a debug link. Bytes come in on a valid-qualified receive stream, and the block assembles them into command frames. Each frame names a word or byte read or a word or byte write at a little-endian address. A frame that passes every check becomes one access on a request/acknowledge memory port with byte enables. When the access completes, the block streams a reply frame out through a valid/ready transmit interface.

A frame that fails any check is dropped without a reply, and the parser goes back to looking for the start byte. This covers a bad start byte, an unsupported length, an unknown or mismatched command code and a wrong checksum. A frame that stalls part-way is also abandoned after a configurable number of idle clocks, so a broken host transfer cannot wedge the parser. The bit-level UART engines (8 data bits, no parity, one stop bit, 19200 baud on the link) sit outside this block, which only sees whole bytes.

Top module: `dbg_mem_cmd`

## Requirements
- R1: During and right after reset, `mem_req` and `tx_valid` are low and the parser is waiting for a start byte.
- R2: While waiting for a frame, every received byte other than 0x39 is ignored. A 0x39 byte starts a frame.
- R3: Frame layout by byte index: [0] 0x39, [1] length L, [2] command code, [3] address low, [4] address high, [5] write data low, [6] write data high, [L] checksum. The checksum is the modulo-256 sum of bytes 1 through L-1. Replies use the same rule: 0x39, length, code, data bytes, checksum.
- R4: Code 1 with L=5 (word read) issues a read (`mem_we`=0, `mem_be`=2'b11) at the address. The reply is 0x39, 0x05, 0x01, data low, data high, checksum.
- R5: Code 2 with L=5 (byte read) issues a read with `mem_be`=2'b01. The reply is 0x39, 0x04, 0x02, `mem_rdata[7:0]`, checksum. `mem_rdata[15:8]` is not used.
- R6: Code 3 with L=7 (word write) issues a write (`mem_we`=1, `mem_be`=2'b11) of {byte 6, byte 5}. The reply is 0x39, 0x03, 0x03, 0x06.
- R7: Code 4 with L=7 (byte write) issues a write with `mem_be`=2'b01. `mem_wdata[7:0]` is byte 5 and `mem_wdata[15:8]` is 0; byte 6 is ignored. The reply is 0x39, 0x03, 0x04, 0x07.
- R8: A frame whose checksum byte does not match produces no memory request and no reply.
- R9: A length other than 5 or 7, a command code outside 1 to 4, or a length that does not fit the code drops the frame with no request and no reply.
- R10: If IDLE_LIMIT consecutive clocks pass without a byte inside a partial frame, the frame is abandoned. With IDLE_LIMIT-1 idle clocks between bytes, the frame is still accepted.
- R11: `mem_req` stays high with stable address, data, write flag and byte enables until the clock on which `mem_ack` is high.
- R12: The reply goes out one byte per clock on which `tx_valid` and `tx_ready` are both high. `tx_data` holds steady while `tx_ready` is low.
- R13: Bytes received while an access or a reply is in progress are discarded.
- R14: A reply starts only after the access is acknowledged, and `mem_req` and `tx_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this clock |
| rx_data | input | 8 | Received byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_be | output | 2 | Byte enables: 2'b11 word, 2'b01 byte |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 16 | Read data |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter accepts the byte |

## Verification
The assertions check the handshake rules on every cycle: the memory request holds steady until it is acknowledged, a pending reply byte does not change, the memory and transmit sides are never active together, and every reply begins with the start byte after an acknowledge. The legal byte-enable values and the zeroed upper lane on byte writes are also checked every cycle. The bench scenarios are what show the frame content: correct addresses and data for each command, reply bytes and checksums, silent dropping of corrupted frames, the idle-timeout boundary, and the discarding of input that arrives while a reply is stalled.

// File: rtl/dbg_mem_cmd.sv
module dbg_mem_cmd #(
  parameter int         IDLE_LIMIT = 4096,
  parameter logic [7:0] SYNC       = 8'h39
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  output logic [1:0]  mem_be,
  input  logic        mem_ack,
  input  logic [15:0] mem_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready
);
  localparam int CW = $clog2(IDLE_LIMIT + 1);
  localparam logic [7:0] LEN_RD = 8'd5;
  localparam logic [7:0] LEN_WR = 8'd7;

  typedef enum logic [2:0] {HUNT, GET_LEN, GET_ID, GET_BODY, ACCESS, REPLY} st_t;

  st_t          st;
  logic [2:0]   pos;
  logic [7:0]   flen, cmd, sum;
  logic [15:0]  addr, wdat, rdat;
  logic [CW-1:0] idle;

  logic       is_read, is_word, in_frame, timed_out, id_ok;
  logic [2:0] rlen;
  logic [7:0] rsum;

  assign is_read   = (cmd == 8'd1) || (cmd == 8'd2);
  assign is_word   = (cmd == 8'd1) || (cmd == 8'd3);
  assign in_frame  = (st == GET_LEN) || (st == GET_ID) || (st == GET_BODY);
  assign timed_out = in_frame && !rx_valid && (idle == CW'(IDLE_LIMIT - 1));
  assign id_ok     = (((rx_data == 8'd1) || (rx_data == 8'd2)) && (flen == LEN_RD)) ||
                     (((rx_data == 8'd3) || (rx_data == 8'd4)) && (flen == LEN_WR));
  assign rlen      = (cmd == 8'd1) ? 3'd5 : (cmd == 8'd2) ? 3'd4 : 3'd3;
  assign rsum      = {5'd0, rlen} + cmd + (is_read ? rdat[7:0] : 8'h00)
                   + ((cmd == 8'd1) ? rdat[15:8] : 8'h00);

  assign mem_req   = (st == ACCESS);
  assign mem_we    = !is_read;
  assign mem_be    = is_word ? 2'b11 : 2'b01;
  assign mem_addr  = addr;
  assign mem_wdata = is_word ? wdat : {8'h00, wdat[7:0]};
  assign tx_valid  = (st == REPLY);

  always_comb begin
    if (pos == 3'd0)      tx_data = SYNC;
    else if (pos == 3'd1) tx_data = {5'd0, rlen};
    else if (pos == 3'd2) tx_data = cmd;
    else if (pos == rlen) tx_data = rsum;
    else if (pos == 3'd3) tx_data = rdat[7:0];
    else                  tx_data = rdat[15:8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= HUNT;
      pos  <= '0;
      flen <= '0;
      cmd  <= '0;
      sum  <= '0;
      addr <= '0;
      wdat <= '0;
      rdat <= '0;
      idle <= '0;
    end else begin
      if (!in_frame || rx_valid) idle <= '0;
      else                       idle <= idle + 1'b1;

      if (timed_out) st <= HUNT;
      else begin
        case (st)
          HUNT:
            if (rx_valid && rx_data == SYNC) st <= GET_LEN;
          GET_LEN:
            if (rx_valid) begin
              flen <= rx_data;
              sum  <= rx_data;
              st   <= (rx_data == LEN_RD || rx_data == LEN_WR) ? GET_ID : HUNT;
            end
          GET_ID:
            if (rx_valid) begin
              cmd <= rx_data;
              sum <= sum + rx_data;
              pos <= 3'd3;
              st  <= id_ok ? GET_BODY : HUNT;
            end
          GET_BODY:
            if (rx_valid) begin
              if (pos == flen[2:0]) begin
                st <= (rx_data == sum) ? ACCESS : HUNT;
              end else begin
                sum <= sum + rx_data;
                pos <= pos + 3'd1;
                case (pos)
                  3'd3:    addr[7:0]  <= rx_data;
                  3'd4:    addr[15:8] <= rx_data;
                  3'd5:    wdat[7:0]  <= rx_data;
                  default: wdat[15:8] <= rx_data;
                endcase
              end
            end
          ACCESS:
            if (mem_ack) begin
              rdat <= mem_rdata;
              pos  <= '0;
              st   <= REPLY;
            end
          REPLY:
            if (tx_ready) begin
              if (pos == rlen) st <= HUNT;
              else             pos <= pos + 3'd1;
            end
          default: st <= HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/dbg_mem_cmd_chk.sv
module dbg_mem_cmd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic [1:0]  mem_be,
  input logic        mem_ack,
  input logic        tx_valid,
  input logic [7:0]  tx_data,
  input logic        tx_ready
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)
                            && $stable(mem_we) && $stable(mem_be));

  assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_exclusive_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && tx_valid));

  assert_reply_after_ack_R14: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(mem_req && mem_ack));

  assert_reply_header_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_data == 8'h39);

  assert_be_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be == 2'b11 || mem_be == 2'b01));

  assert_byte_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_be == 2'b01 |-> mem_wdata[15:8] == 8'h00);
endmodule

bind dbg_mem_cmd dbg_mem_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
  .mem_ack(mem_ack), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
);

// File: tb/dbg_mem_cmd_bench.sv
`timescale 1ns/1ps
module dbg_mem_cmd_bench;
  localparam int LIM = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_be;
  logic        tx_valid, tx_ready;
  logic [7:0]  tx_data;

  always #2.5 clk = ~clk;

  dbg_mem_cmd #(.IDLE_LIMIT(LIM)) u_dbg_mem_cmd (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready));

  int n_chk = 0, n_err = 0;
  bit done = 0;
  bit stall = 0;

  int          req_n = 0;
  logic        cap_we;
  logic [1:0]  cap_be;
  logic [15:0] cap_addr, cap_wdata;
  int          rq_n = 0;
  logic [7:0]  rq [0:63];
  logic [7:0]  fr [0:15];
  int          fn;

  function automatic logic [15:0] mval(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'hC3};
  endfunction

  initial begin
    mem_ack = 1'b0;
    mem_rdata = 16'h0000;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req && ($urandom % 3 == 0)) begin
        mem_ack = 1'b1;
        mem_rdata = mval(mem_addr);
        cap_we = mem_we; cap_be = mem_be; cap_addr = mem_addr; cap_wdata = mem_wdata;
        req_n++;
      end
    end
  end

  initial begin
    tx_ready = 1'b0;
    forever begin
      @(negedge clk);
      tx_ready = !stall && ($urandom % 4 != 0);
      if (tx_valid && tx_ready) begin
        rq[rq_n % 64] = tx_data;
        rq_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic seal();
    logic [7:0] s;
    s = 8'h00;
    for (int i = 1; i < int'(fr[1]); i++) s += fr[i];
    fr[fr[1]] = s;
    fn = int'(fr[1]) + 1;
  endtask

  task automatic build(input logic [7:0] c, input logic [15:0] a, input logic [15:0] d);
    fr[0] = 8'h39;
    fr[1] = (c > 8'd2) ? 8'd7 : 8'd5;
    fr[2] = c;
    fr[3] = a[7:0];
    fr[4] = a[15:8];
    fr[5] = d[7:0];
    fr[6] = d[15:8];
    seal();
  endtask

  task automatic send_frame(input int gapmax);
    for (int i = 0; i < fn; i++) send_byte(fr[i], $urandom % (gapmax + 1));
  endtask

  task automatic check_txn(input string tag, input bit ok_exp, input int rb, input int qb,
                           input logic [7:0] c, input logic [15:0] a, input logic [15:0] d);
    logic [7:0]  er [0:7];
    logic [15:0] rv;
    int en, w;
    rv = mval(a);
    er[0] = 8'h39; er[2] = c;
    if (c == 8'd1) begin en = 6; er[1] = 8'd5; er[3] = rv[7:0]; er[4] = rv[15:8]; end
    else if (c == 8'd2) begin en = 5; er[1] = 8'd4; er[3] = rv[7:0]; end
    else begin en = 4; er[1] = 8'd3; end
    er[en-1] = 8'h00;
    for (int i = 1; i < en - 1; i++) er[en-1] += er[i];
    w = 0;
    while (ok_exp && (rq_n - qb) < en && w < 400) begin @(negedge clk); w++; end
    repeat (LIM + 10) @(negedge clk);
    chk(req_n - rb == (ok_exp ? 1 : 0), tag, "memory request count R14", req_n - rb, ok_exp ? 1 : 0);
    chk(rq_n - qb == (ok_exp ? en : 0), tag, "reply byte count R12", rq_n - qb, ok_exp ? en : 0);
    if (ok_exp && req_n - rb == 1) begin
      chk(cap_addr == a, tag, "address R11", cap_addr, a);
      chk(cap_we == (c > 8'd2), tag, "write flag", cap_we, c > 8'd2);
      chk(cap_be == ((c == 8'd1 || c == 8'd3) ? 2'b11 : 2'b01), tag, "byte enables", cap_be,
          (c == 8'd1 || c == 8'd3) ? 3 : 1);
      if (c == 8'd3) chk(cap_wdata == d, tag, "write data R6", cap_wdata, d);
      if (c == 8'd4) chk(cap_wdata == {8'h00, d[7:0]}, tag, "write data R7", cap_wdata, {8'h00, d[7:0]});
    end
    if (ok_exp && rq_n - qb == en)
      for (int i = 0; i < en; i++)
        chk(rq[(qb + i) % 64] == er[i], tag, $sformatf("reply byte %0d R3 R12", i), rq[(qb + i) % 64], er[i]);
  endtask

  function automatic logic [7:0] no_sync(input logic [7:0] b);
    return (b == 8'h39) ? 8'h38 : b;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int rb, qb;
    logic [7:0]  c;
    logic [15:0] a, d;
    void'($urandom(32'd4321));
    rst_n = 1'b0; rx_valid = 1'b0; rx_data = 8'h00;
    repeat (4) @(negedge clk);
    chk(!mem_req && !tx_valid, "R1", "outputs in reset", {mem_req, tx_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!mem_req && !tx_valid, "R1", "outputs after reset", {mem_req, tx_valid}, 0);

    // R2: junk before a header, then word read
    rb = req_n; qb = rq_n;
    send_byte(8'h00, 0); send_byte(8'hFF, 1); send_byte(8'h38, 0);
    build(8'd1, 16'h1234, 16'h0); send_frame(2);
    check_txn("R2 R4", 1, rb, qb, 8'd1, 16'h1234, 16'h0);

    // R10 boundary: LIM-1 idle clocks between bytes is accepted
    rb = req_n; qb = rq_n;
    build(8'd2, 16'hBEEF, 16'h0);
    for (int i = 0; i < fn; i++) send_byte(fr[i], LIM - 1);
    check_txn("R10 R5", 1, rb, qb, 8'd2, 16'hBEEF, 16'h0);

    // R10: partial frame abandoned after LIM idle clocks
    rb = req_n; qb = rq_n;
    send_byte(8'h39, 0); send_byte(8'h07, LIM);
    build(8'd3, 16'h0102, 16'hA55A); send_frame(1);
    check_txn("R10 R6", 1, rb, qb, 8'd3, 16'h0102, 16'hA55A);

    // R7: byte 6 ignored on byte write
    rb = req_n; qb = rq_n;
    build(8'd4, 16'hFFFF, 16'hEE77); send_frame(0);
    check_txn("R7", 1, rb, qb, 8'd4, 16'hFFFF, 16'hEE77);

    // R8: checksum off by one
    rb = req_n; qb = rq_n;
    build(8'd1, 16'h4000, 16'h0); fr[fn-1] = fr[fn-1] + 8'd1; send_frame(1);
    check_txn("R8", 0, rb, qb, 8'd1, 16'h4000, 16'h0);

    // R9: length 7 with a read code, checksum consistent
    rb = req_n; qb = rq_n;
    build(8'd3, 16'h2222, 16'h1111); fr[2] = 8'd1; seal(); send_frame(1);
    check_txn("R9", 0, rb, qb, 8'd1, 16'h2222, 16'h0);

    // R9: unknown code 5
    rb = req_n; qb = rq_n;
    build(8'd1, 16'h2222, 16'h0); fr[2] = 8'd5; seal(); send_frame(1);
    check_txn("R9", 0, rb, qb, 8'd1, 16'h2222, 16'h0);

    // R13: second frame arrives while reply stalled
    rb = req_n; qb = rq_n;
    stall = 1;
    build(8'd1, 16'h0A0B, 16'h0); send_frame(0);
    repeat (30) @(negedge clk);
    build(8'd3, 16'h0C0D, 16'h1234); send_frame(0);
    stall = 0;
    check_txn("R13", 1, rb, qb, 8'd1, 16'h0A0B, 16'h0);

    // constrained random mix
    for (int k = 0; k < 40; k++) begin
      int kind;
      kind = $urandom % 7;
      c = 8'(($urandom % 4) + 1);
      a = 16'($urandom);
      d = 16'($urandom);
      rb = req_n; qb = rq_n;
      if ($urandom % 3 == 0) send_byte(no_sync(8'($urandom)), $urandom % 3);
      if (kind < 5) begin
        build(c, a, d); send_frame(3);
        check_txn(c == 8'd1 ? "R4" : c == 8'd2 ? "R5" : c == 8'd3 ? "R6" : "R7", 1, rb, qb, c, a, d);
      end else begin
        a = {no_sync(a[15:8]), no_sync(a[7:0])};
        d = {no_sync(d[15:8]), no_sync(d[7:0])};
        build(c, a, d);
        if (kind == 5) fr[fn-1] = fr[fn-1] ^ 8'h10;
        else fr[2] = 8'(($urandom % 2) ? 0 : 6);
        if (kind == 6) seal();
        send_frame(3);
        check_txn(kind == 5 ? "R8" : "R9", 0, rb, qb, c, a, d);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule